// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits between the ECC encoder of a RAM and the RAM array. The RAM is protected by a 32-bit SEC-DED code, so each stored word has 39 bits: 32 data bits and 7 check bits. The block receives the data and check bits that the encoder has already computed. It can then invert chosen bits of that word so that the decoder's single-bit correction and double-bit detection paths can be tested with real stored errors.

A 7-bit position field selects the bit to corrupt. Values 0 to 31 select a data bit. Values 64 to 70 select a check bit. Every other value selects nothing. Four level enables choose the kind of corruption:
- continuous single-bit
- one-shot single-bit
- continuous two-bit
- one-shot two-bit

A two-bit corruption pairs the selected bit with check bit 0, which is the overall odd-parity bit of the code. A one-shot enable corrupts exactly one write after it goes high, and it has to be seen low before it can fire again. The result is registered, and it leaves the block one cycle after the write strobe.

Top module: `ecc_wr_inject`

## Requirements
- R1: One clock after a cycle with `wr_en` high, `out_vld` is high and `out_data`/`out_chk` carry that cycle's `wr_data`/`wr_chk` with the selected inversions applied. One clock after a cycle with `wr_en` low, `out_vld` is low.
- R2: With a single-bit mode active, a position value p in 0..31 inverts `out_data[p]` only.
- R3: With a single-bit mode active, a position value p in 64..70 inverts `out_chk[p-64]` only.
- R4: Position values 32..63 and 71..127 invert no bit in any mode.
- R5: A two-bit mode inverts the bit that the single-bit mode would invert, and also inverts `out_chk[0]`. With position 64 the two inversions land on the same bit, so the word passes through unchanged.
- R6: A continuous enable (`cont_sb_en` single-bit, `cont_db_en` two-bit) applies its inversion on every write while the enable is high.
- R7: A one-shot enable (`once_sb_en` single-bit, `once_db_en` two-bit) applies its inversion only on the first write after the enable rises. Later writes while the enable stays high pass through unchanged.
- R8: A one-shot enable re-arms only after it has been sampled low for at least one clock. If it drops before any write, the pending injection is discarded.
- R9: When more than one of the four enables is high, every write passes through unchanged, and a pending one-shot is not consumed.
- R10: While `rst` is high, the next clock drives `out_vld` low and `out_data`/`out_chk` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_sb_en | input | 1 | Continuous single-bit injection enable |
| once_sb_en | input | 1 | One-shot single-bit injection enable |
| cont_db_en | input | 1 | Continuous two-bit injection enable |
| once_db_en | input | 1 | One-shot two-bit injection enable |
| err_pos | input | 7 | Position value: 0..31 data bit, 64..70 check bit |
| wr_en | input | 1 | Write strobe from the encoder side |
| wr_data | input | 32 | Data bits from the encoder |
| wr_chk | input | 7 | Check bits from the encoder |
| out_vld | output | 1 | Registered write strobe toward the RAM |
| out_data | output | 32 | Data bits to store, possibly corrupted |
| out_chk | output | 7 | Check bits to store, possibly corrupted |

## Verification
Some properties are checked on every cycle:
- The output strobe follows the input strobe after one cycle, and reset clears the outputs.
- Conflicting enables always give a clean pass-through.
- A write never differs from its input in more than two bits.
- A lone two-bit mode never produces a single-bit difference.
- A lone continuous single-bit mode at a data position gives exactly one flipped bit.
- A one-shot enable held high through two back-to-back writes leaves the second write clean.

Other behaviour needs the bench's scenarios, because it depends on the exact bit chosen or on a history of several cycles:
- the exact bit mapped from each position value
- the gaps and the cancellation at position 64
- re-arming after the enable goes low
- losing a pending shot when the enable drops before a write

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int DATA_W   = 32;
  localparam int CHK_W    = 7;
  localparam int POS_W    = 7;
  localparam int CHK_BASE = 64;
  localparam int WORD_W   = DATA_W + CHK_W;
  localparam int N_EN     = 4;

  // Bit index of each enable in the packed enable vector.
  localparam int EN_SB_CONT = 0;
  localparam int EN_SB_ONCE = 1;
  localparam int EN_DB_CONT = 2;
  localparam int EN_DB_ONCE = 3;

  typedef enum logic [1:0] {
    INJ_NONE   = 2'd0,
    INJ_SINGLE = 2'd1,
    INJ_DOUBLE = 2'd2
  } inj_mode_e;
endpackage

// File: rtl/inj_pos_decode.sv
// Turns the position value into a one-hot (or empty) mask over the stored word.
// The mask layout is {check bits, data bits}.
module inj_pos_decode #(
  parameter int DATA_W   = 32,
  parameter int CHK_W    = 7,
  parameter int POS_W    = 7,
  parameter int CHK_BASE = 64,
  localparam int WORD_W  = DATA_W + CHK_W
) (
  input  logic [POS_W-1:0]  pos,
  output logic [WORD_W-1:0] single_mask
);
  generate
    if (DATA_W > CHK_BASE) begin : g_bad_layout
      initial $error("data field overlaps check field in position map");
    end
    for (genvar i = 0; i < DATA_W; i++) begin : g_data
      assign single_mask[i] = (pos == POS_W'(i));
    end
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
      assign single_mask[DATA_W + k] = (pos == POS_W'(CHK_BASE + k));
    end
  endgenerate
endmodule

// File: rtl/inj_oneshot.sv
// Arms on a rising edge of a one-shot enable, fires once, and waits for
// the enable to be seen low before it can arm again.
module inj_oneshot (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic consume,
  output logic armed
);
  logic en_q;
  logic armed_q;

  always_comb begin
    armed = en && (armed_q || !en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q    <= en;
      armed_q <= armed && !consume;
    end
  end
endmodule

// File: rtl/inj_mode_sel.sv
// Picks the active injection mode from the enables and the one-shot arm flags.
module inj_mode_sel
  import ecc_inj_pkg::*;
#(
  parameter int N_EN_P = N_EN
) (
  input  logic [N_EN_P-1:0] en,
  input  logic              sb_armed,
  input  logic              db_armed,
  output logic              legal,
  output inj_mode_e         mode
);
  always_comb begin
    legal = ($countones(en) <= 1);
    mode  = INJ_NONE;
    if (legal) begin
      if (en[EN_SB_CONT] || (en[EN_SB_ONCE] && sb_armed)) mode = INJ_SINGLE;
      if (en[EN_DB_CONT] || (en[EN_DB_ONCE] && db_armed)) mode = INJ_DOUBLE;
    end
  end
endmodule

// File: rtl/ecc_wr_inject.sv
module ecc_wr_inject
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W_P   = DATA_W,
  parameter int CHK_W_P    = CHK_W,
  parameter int POS_W_P    = POS_W,
  parameter int CHK_BASE_P = CHK_BASE,
  localparam int WORD_W_L  = DATA_W_P + CHK_W_P
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cont_sb_en,
  input  logic                once_sb_en,
  input  logic                cont_db_en,
  input  logic                once_db_en,
  input  logic [POS_W_P-1:0]  err_pos,
  input  logic                wr_en,
  input  logic [DATA_W_P-1:0] wr_data,
  input  logic [CHK_W_P-1:0]  wr_chk,
  output logic                out_vld,
  output logic [DATA_W_P-1:0] out_data,
  output logic [CHK_W_P-1:0]  out_chk
);
  localparam int N_ONCE = 2;

  logic [N_EN-1:0]     en_vec;
  logic [N_ONCE-1:0]   once_en;
  logic [N_ONCE-1:0]   once_armed;
  logic                legal;
  inj_mode_e           mode;
  logic [WORD_W_L-1:0] single_mask;
  logic [WORD_W_L-1:0] parity_bit;
  logic [WORD_W_L-1:0] double_mask;
  logic [WORD_W_L-1:0] flip_mask;
  logic [WORD_W_L-1:0] word_in;
  logic [WORD_W_L-1:0] word_q;
  logic                vld_q;

  always_comb begin
    en_vec             = '0;
    en_vec[EN_SB_CONT] = cont_sb_en;
    en_vec[EN_SB_ONCE] = once_sb_en;
    en_vec[EN_DB_CONT] = cont_db_en;
    en_vec[EN_DB_ONCE] = once_db_en;
    once_en            = {once_db_en, once_sb_en};
  end

  // One arm tracker per one-shot enable. A shot is used up only by a write
  // that is actually allowed to inject.
  generate
    for (genvar s = 0; s < N_ONCE; s++) begin : g_once
      inj_oneshot u_shot (
        .clk     (clk),
        .rst     (rst),
        .en      (once_en[s]),
        .consume (wr_en && legal),
        .armed   (once_armed[s])
      );
    end
  endgenerate

  inj_mode_sel #(.N_EN_P(N_EN)) u_sel (
    .en       (en_vec),
    .sb_armed (once_armed[0]),
    .db_armed (once_armed[1]),
    .legal    (legal),
    .mode     (mode)
  );

  inj_pos_decode #(
    .DATA_W   (DATA_W_P),
    .CHK_W    (CHK_W_P),
    .POS_W    (POS_W_P),
    .CHK_BASE (CHK_BASE_P)
  ) u_dec (
    .pos         (err_pos),
    .single_mask (single_mask)
  );

  // The two-bit pattern adds the overall parity bit (check bit 0). A gap
  // position leaves the whole pattern empty, and position 64 cancels itself.
  always_comb begin
    parity_bit           = '0;
    parity_bit[DATA_W_P] = |single_mask;
    double_mask          = single_mask ^ parity_bit;
    unique case (mode)
      INJ_SINGLE: flip_mask = single_mask;
      INJ_DOUBLE: flip_mask = double_mask;
      default:    flip_mask = '0;
    endcase
    word_in = {wr_chk, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= wr_en;
      if (wr_en) word_q <= word_in ^ flip_mask;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = word_q[DATA_W_P-1:0];
  assign out_chk  = word_q[WORD_W_L-1:DATA_W_P];
endmodule

// File: rtl/ecc_wr_inject_chk.sv
module ecc_wr_inject_chk #(
  parameter int DATA_W_P   = 32,
  parameter int CHK_W_P    = 7,
  parameter int POS_W_P    = 7,
  parameter int CHK_BASE_P = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                cont_sb_en,
  input logic                once_sb_en,
  input logic                cont_db_en,
  input logic                once_db_en,
  input logic [POS_W_P-1:0]  err_pos,
  input logic                wr_en,
  input logic [DATA_W_P-1:0] wr_data,
  input logic [CHK_W_P-1:0]  wr_chk,
  input logic                out_vld,
  input logic [DATA_W_P-1:0] out_data,
  input logic [CHK_W_P-1:0]  out_chk
);
  logic [3:0]                  ens;
  logic [DATA_W_P+CHK_W_P-1:0] in_word;
  logic [DATA_W_P+CHK_W_P-1:0] out_word;
  logic                        once_only;

  assign ens       = {once_db_en, cont_db_en, once_sb_en, cont_sb_en};
  assign in_word   = {wr_chk, wr_data};
  assign out_word  = {out_chk, out_data};
  assign once_only = (ens == 4'b0010) || (ens == 4'b1000);

  assert_vld_follow_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> out_vld);
  assert_vld_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !out_vld);
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_vld && out_data == '0 && out_chk == '0));
  assert_conflict_clean_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $countones(ens) > 1) |=> (out_word == $past(in_word)));
  assert_max_two_flips_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ($countones(out_word ^ $past(in_word)) <= 2));
  assert_double_never_one_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ens == 4'b0100) |=> ($countones(out_word ^ $past(in_word)) != 1));
  assert_cont_single_data_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ens == 4'b0001 && err_pos < POS_W_P'(DATA_W_P))
      |=> ($countones(out_word ^ $past(in_word)) == 1));
  assert_once_second_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && once_only && $past(!rst) && $past(wr_en) && $past(ens) == ens)
      |=> (out_word == $past(in_word)));
endmodule

bind ecc_wr_inject ecc_wr_inject_chk #(
  .DATA_W_P   (DATA_W_P),
  .CHK_W_P    (CHK_W_P),
  .POS_W_P    (POS_W_P),
  .CHK_BASE_P (CHK_BASE_P)
) i_chk (.*);

// File: tb/test_ecc_wr_inject.sv
`timescale 1ns/1ps
module test_ecc_wr_inject;
  logic        clk = 1'b0;
  logic        rst;
  logic        cont_sb_en, once_sb_en, cont_db_en, once_db_en;
  logic [6:0]  err_pos;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [6:0]  wr_chk;
  logic        out_vld;
  logic [31:0] out_data;
  logic [6:0]  out_chk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ecc_wr_inject i_ecc_wr_inject (
    .clk(clk), .rst(rst),
    .cont_sb_en(cont_sb_en), .once_sb_en(once_sb_en),
    .cont_db_en(cont_db_en), .once_db_en(once_db_en),
    .err_pos(err_pos), .wr_en(wr_en), .wr_data(wr_data), .wr_chk(wr_chk),
    .out_vld(out_vld), .out_data(out_data), .out_chk(out_chk)
  );

  // Each entry: {mode[1:0] (1 = continuous single, 2 = continuous two-bit),
  //              pos[6:0], expected flip mask[38:0] as {chk, data}}
  localparam int NV = 11;
  localparam logic [47:0] VEC [NV] = '{
    {2'd1, 7'd0,   39'h00_0000_0001},  // R2
    {2'd1, 7'd31,  39'h00_8000_0000},  // R2
    {2'd1, 7'd40,  39'h00_0000_0000},  // R4
    {2'd1, 7'd64,  39'h01_0000_0000},  // R3
    {2'd1, 7'd70,  39'h40_0000_0000},  // R3
    {2'd1, 7'd127, 39'h00_0000_0000},  // R4
    {2'd2, 7'd5,   39'h01_0000_0020},  // R5
    {2'd2, 7'd64,  39'h00_0000_0000},  // R5
    {2'd2, 7'd66,  39'h05_0000_0000},  // R5
    {2'd2, 7'd50,  39'h00_0000_0000},  // R4
    {2'd2, 7'd31,  39'h01_8000_0000}   // R5
  };

  task automatic check(input bit ok, input string req, input logic [38:0] act,
                       input logic [38:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one write at a falling edge; the result is registered at the
  // next rising edge and is sampled at the falling edge after it.
  task automatic wr(input logic [31:0] d, input logic [6:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_chk = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_word(input logic [31:0] d, input logic [6:0] c,
                             input logic [38:0] flip, input string req);
    logic [38:0] exp;
    exp = {c, d} ^ flip;
    check(out_vld && {out_chk, out_data} == exp, req, {out_chk, out_data}, exp);
  endtask

  task automatic set_en(input logic [3:0] e);
    @(negedge clk);
    {once_db_en, cont_db_en, once_sb_en, cont_sb_en} = e;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; wr_chk = '0; err_pos = '0;
    {once_db_en, cont_db_en, once_sb_en, cont_sb_en} = 4'b0;
    repeat (3) @(negedge clk);
    check(!out_vld && out_data == 0 && out_chk == 0, "R10 reset",
          {out_chk, out_data}, 39'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_vld, "R1 idle", {38'h0, out_vld}, 39'h0);

    // No enable: clean pass-through
    wr(32'hA5A5_0F0F, 7'h2B);
    expect_word(32'hA5A5_0F0F, 7'h2B, 39'h0, "R1 pass");
    @(negedge clk);
    check(!out_vld, "R1 strobe drop", {38'h0, out_vld}, 39'h0);

    // Table of continuous-mode vectors, two writes each
    for (int i = 0; i < NV; i++) begin
      err_pos = VEC[i][45:39];
      set_en((VEC[i][47:46] == 2'd1) ? 4'b0001 : 4'b0100);
      for (int k = 0; k < 2; k++) begin
        wr(32'h1357_9BDF ^ (i * 32'h0101_0101), 7'h55 ^ 7'(i));
        expect_word(32'h1357_9BDF ^ (i * 32'h0101_0101), 7'h55 ^ 7'(i),
                    VEC[i][38:0], $sformatf("R6 vec %0d write %0d", i, k));
      end
      set_en(4'b0);
    end

    // One-shot single-bit: fires once, stays quiet, re-arms after low (R7, R8)
    err_pos = 7'd3;
    set_en(4'b0010);
    wr(32'h0, 7'h0);
    expect_word(32'h0, 7'h0, 39'h8, "R7 once sb first");
    wr(32'h0, 7'h0);
    expect_word(32'h0, 7'h0, 39'h0, "R7 once sb second");
    set_en(4'b0);
    set_en(4'b0010);
    wr(32'hFFFF_FFFF, 7'h7F);
    expect_word(32'hFFFF_FFFF, 7'h7F, 39'h8, "R8 rearm");

    // One-shot two-bit
    err_pos = 7'd68;
    set_en(4'b0);
    set_en(4'b1000);
    wr(32'h1234_5678, 7'h11);
    expect_word(32'h1234_5678, 7'h11, 39'h11_0000_0000, "R7 once db first");
    wr(32'h1234_5678, 7'h11);
    expect_word(32'h1234_5678, 7'h11, 39'h0, "R7 once db second");

    // Enable dropped before any write discards the shot (R8)
    set_en(4'b0);
    set_en(4'b1000);
    set_en(4'b0);
    wr(32'h1234_5678, 7'h11);
    expect_word(32'h1234_5678, 7'h11, 39'h0, "R8 dropped shot");

    // Conflicting enables pass through and keep the shot pending (R9)
    err_pos = 7'd7;
    set_en(4'b0101);
    wr(32'hCAFE_F00D, 7'h3C);
    expect_word(32'hCAFE_F00D, 7'h3C, 39'h0, "R9 two continuous");
    set_en(4'b0);
    set_en(4'b0010);
    set_en(4'b0011);
    wr(32'hCAFE_F00D, 7'h3C);
    expect_word(32'hCAFE_F00D, 7'h3C, 39'h0, "R9 once plus cont");
    set_en(4'b0010);
    wr(32'hCAFE_F00D, 7'h3C);
    expect_word(32'hCAFE_F00D, 7'h3C, 39'h80, "R9 shot kept");

    // Reset during activity clears the outputs (R10)
    wr(32'hDEAD_BEEF, 7'h01);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!out_vld && out_data == 0 && out_chk == 0, "R10 mid reset",
          {out_chk, out_data}, 39'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule